// File: doc/BRIEF.md
# Line BIP-8 Error Monitor

This block watches a descrambled, byte-wide STS-3 receive stream. The stream carries a start-of-frame marker on the first byte of each frame. The block tracks the row and column of every accepted byte and keeps three interleaved BIP-8 parities, one per STS-1 channel. The channel of a byte is its column index modulo 3, counted from zero. Every byte of the frame goes into the parity except the section overhead, which is rows 1 to 3 of the nine transport overhead columns.

When a frame ends, its parities are held. They are then compared bit by bit with the three B2 bytes of the following frame. Those bytes sit in row 5, columns 1 to 3. Mismatches feed a 32-bit saturating error counter. The counter steps either once per errored frame or by the number of mismatched bits, up to 24 per frame. Mismatches also set a read-to-clear status bit, which drives an active-low interrupt pin when enabled.

The input is a valid/ready stream, and the block never applies back-pressure: `in_ready` is always high, and a byte is taken on every cycle where `in_valid` is high. Cycles with `in_valid` low leave all state unchanged. The frame geometry assumes the column count is a multiple of the channel count. Software reads the counter and the status through a small byte-wide read port.

Top module: `b2_monitor`

## Requirements
- R1: `in_ready` is 1 at all times after reset. Only bytes with `in_valid`=1 advance the position. A byte with `in_sof`=1 is row 1, column 1 and restarts the position even in the middle of a frame. Bytes seen before the first marker are ignored.
- R2: Parity channel k (k = 0, 1, 2) is the XOR of every accepted byte whose zero-based column modulo 3 equals k. Bytes in rows 1 to 3 of columns 1 to 9 are left out. The B2 bytes themselves are included.
- R3: The parity of one frame is compared with the B2 bytes of the next frame. Byte k is at row 5, column k+1, and is compared with channel k. A frame is the bytes from one marker up to the next.
- R4: No comparison is made in the first frame after reset, because no complete previous frame exists yet.
- R5: With `per_frame`=1, a frame whose three B2 bytes show at least one mismatched bit adds exactly 1 to the counter.
- R6: With `per_frame`=0, a frame adds the total number of mismatched B2 bits, from 0 to 24.
- R7: The counter saturates at all ones instead of wrapping.
- R8: The read port is sampled when `rd_en`=1, and `rd_data` holds the result from the next clock edge. Address 0 returns counter bits 7:0, snapshots the whole counter and clears it. Addresses 1 to 3 return snapshot bits 15:8, 23:16 and 31:24 and clear that snapshot byte.
- R9: Any mismatch in a frame sets status bit 4. A read of address 4 returns the status byte (0x10 when set, 0x00 otherwise) and clears the bit. A mismatch in the same cycle as the read keeps the bit set.
- R10: `int_n` is 0 exactly when status bit 4 is set and `int_en`=1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready, always 1 |
| in_data | input | 8 | Descrambled stream byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| per_frame | input | 1 | Counting mode: 1 counts once per errored frame, 0 counts per bit |
| int_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | 0 to 3 select a counter byte, 4 selects the status byte |
| rd_data | output | 8 | Registered read data |
| int_n | output | 1 | Active-low interrupt |

## Verification
A fault in the position counters or in the section overhead exclusion makes the held parity differ from the bytes sent. Such a fault therefore shows as a nonzero counter delta on a clean frame, one frame after the faulty frame is received. A fault in the previous-frame latch or in the first-frame guard shows at the third B2 byte of the same frame, as a wrong counter delta, an unexpected status bit or a falling `int_n`. Faults in saturation, the snapshot or the read-clear logic show on the very next read, as wrong bytes or as a nonzero value on a repeated read.

// File: rtl/b2m_pkg.sv
package b2m_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 3'd4;

  function automatic logic [3:0] pop8(input logic [BYTE_W-1:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/b2m_position.sv
module b2m_position #(
  parameter int ROWS     = 9,
  parameter int COLS     = 270,
  parameter int OH_COLS  = 9,
  parameter int SOH_ROWS = 3,
  parameter int B2_ROW   = 4,
  parameter int NCH      = 3,
  localparam int HW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          sof,
  output logic          frame_start,
  output logic          acc_en,
  output logic [HW-1:0] ch,
  output logic          b2_slot,
  output logic          b2_last
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam logic [RW-1:0] L_SOH   = RW'(SOH_ROWS);
  localparam logic [RW-1:0] L_B2R   = RW'(B2_ROW);
  localparam logic [RW-1:0] L_RLAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] L_OH    = CW'(OH_COLS);
  localparam logic [CW-1:0] L_NCH   = CW'(NCH);
  localparam logic [CW-1:0] L_NLAST = CW'(NCH - 1);
  localparam logic [CW-1:0] L_CLAST = CW'(COLS - 1);
  localparam logic [HW-1:0] L_HLAST = HW'(NCH - 1);

  logic [RW-1:0] row_q, cur_row;
  logic [CW-1:0] col_q, cur_col;
  logic [HW-1:0] ch_q, cur_ch;
  logic          sync_q, live;

  always_comb begin
    cur_row     = sof ? '0 : row_q;
    cur_col     = sof ? '0 : col_q;
    cur_ch      = sof ? '0 : ch_q;
    frame_start = take && sof;
    live        = take && (sof || sync_q);
    acc_en      = live && !((cur_row < L_SOH) && (cur_col < L_OH));
    b2_slot     = live && (cur_row == L_B2R) && (cur_col < L_NCH);
    b2_last     = b2_slot && (cur_col == L_NLAST);
    ch          = cur_ch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      ch_q   <= '0;
      sync_q <= 1'b0;
    end else if (live) begin
      sync_q <= 1'b1;
      if (cur_col == L_CLAST) begin
        col_q <= '0;
        ch_q  <= '0;
        row_q <= (cur_row == L_RLAST) ? '0 : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        ch_q  <= (cur_ch == L_HLAST) ? '0 : cur_ch + 1'b1;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/b2m_parity.sv
module b2m_parity
  import b2m_pkg::*;
#(
  parameter int NCH = 3,
  localparam int HW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW = $clog2(NCH * BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              acc_en,
  input  logic [HW-1:0]     ch,
  input  logic              b2_slot,
  input  logic              b2_last,
  input  logic [BYTE_W-1:0] data,
  output logic              have_prev,
  output logic              fire,
  output logic [BW-1:0]     bits
);
  logic [BYTE_W-1:0] acc_q  [NCH];
  logic [BYTE_W-1:0] prev_q [NCH];
  logic              seen_q, have_q;
  logic [BW-1:0]     err_q, cur_bits;
  logic [BYTE_W-1:0] mism;
  logic              chk;

  always_comb begin
    mism     = data ^ prev_q[ch];
    cur_bits = BW'(pop8(mism));
    chk      = b2_slot && have_q;
    fire     = b2_last && have_q;
    bits     = err_q + cur_bits;
    have_prev = have_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        acc_q[i]  <= '0;
        prev_q[i] <= '0;
      end
      seen_q <= 1'b0;
      have_q <= 1'b0;
      err_q  <= '0;
    end else begin
      if (frame_start) begin
        for (int i = 0; i < NCH; i++) begin
          prev_q[i] <= acc_q[i];
          acc_q[i]  <= (acc_en && ch == HW'(i)) ? data : '0;
        end
        have_q <= seen_q;
        seen_q <= 1'b1;
        err_q  <= '0;
      end else if (acc_en) begin
        for (int i = 0; i < NCH; i++)
          if (ch == HW'(i)) acc_q[i] <= acc_q[i] ^ data;
      end
      if (chk) err_q <= b2_last ? '0 : bits;
    end
  end
endmodule

// File: rtl/b2m_counter.sv
module b2m_counter
  import b2m_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BW-1:0]     bits,
  input  logic              per_frame,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_q, snap_q, base, nxt;
  logic [CNT_W:0]   inc, sum;
  logic             rd_low;

  always_comb begin
    rd_low = rd_en && (rd_addr == '0);
    inc    = '0;
    if (fire) inc = per_frame ? (CNT_W+1)'(bits != '0) : (CNT_W+1)'(bits);
    base   = rd_low ? '0 : cnt_q;
    sum    = {1'b0, base} + inc;
    nxt    = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    cnt_o  = cnt_q;
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NB; k++)
      if (rd_addr == ADDR_W'(k))
        rd_byte = (k == 0) ? cnt_q[BYTE_W-1:0] : snap_q[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q <= nxt;
      if (rd_low) snap_q <= cnt_q;
      else if (rd_en)
        for (int k = 1; k < NB; k++)
          if (rd_addr == ADDR_W'(k)) snap_q[k*BYTE_W +: BYTE_W] <= '0;
    end
  end
endmodule

// File: rtl/b2_monitor.sv
module b2_monitor
  import b2m_pkg::*;
#(
  parameter int ROWS     = 9,
  parameter int COLS     = 270,
  parameter int OH_COLS  = 9,
  parameter int SOH_ROWS = 3,
  parameter int B2_ROW   = 4,
  parameter int NCH      = 3,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              per_frame,
  input  logic              int_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              int_n
);
  localparam int HW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BW = $clog2(NCH * BYTE_W + 1);
  localparam int NB = CNT_W / BYTE_W;

  logic              frame_start, acc_en, b2_slot, b2_last;
  logic [HW-1:0]     ch;
  logic              have_prev, fire, err_evt;
  logic [BW-1:0]     bits;
  logic [CNT_W-1:0]  cnt_live;
  logic [BYTE_W-1:0] cnt_byte;
  logic              st_q;
  logic [BYTE_W-1:0] rd_q;

  assign in_ready = 1'b1;

  b2m_position #(
    .ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS),
    .SOH_ROWS(SOH_ROWS), .B2_ROW(B2_ROW), .NCH(NCH)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .take(in_valid), .sof(in_sof),
    .frame_start(frame_start), .acc_en(acc_en), .ch(ch),
    .b2_slot(b2_slot), .b2_last(b2_last)
  );

  b2m_parity #(.NCH(NCH)) u_par (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .acc_en(acc_en),
    .ch(ch), .b2_slot(b2_slot), .b2_last(b2_last), .data(in_data),
    .have_prev(have_prev), .fire(fire), .bits(bits)
  );

  b2m_counter #(.CNT_W(CNT_W), .BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fire(fire), .bits(bits),
    .per_frame(per_frame), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt_o(cnt_live), .rd_byte(cnt_byte)
  );

  assign err_evt = fire && (bits != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= 1'b0;
      rd_q <= '0;
    end else begin
      if (rd_en && rd_addr == STATUS_ADDR) begin
        rd_q <= {3'b000, st_q, 4'b0000};
        st_q <= err_evt;
      end else begin
        if (rd_en) rd_q <= (32'(rd_addr) < NB) ? cnt_byte : '0;
        st_q <= st_q || err_evt;
      end
    end
  end

  assign rd_data = rd_q;
  assign int_n   = !(st_q && int_en);
endmodule

// File: rtl/b2m_chk.sv
module b2m_chk #(
  parameter int CNT_W = 32,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             have_prev,
  input logic             per_frame,
  input logic             rd_en,
  input logic [2:0]       rd_addr,
  input logic             st,
  input logic             int_en,
  input logic             int_n
);
  logic no_rd0;
  assign no_rd0 = !(rd_en && rd_addr == 3'd0);

  // R7: without a clearing read the counter never goes down
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    no_rd0 |=> cnt >= $past(cnt));

  // R6: one edge never adds more than 24 (three bytes of bits)
  a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    no_rd0 |=> ((CNT_W+1)'(cnt) - (CNT_W+1)'($past(cnt))) <= (CNT_W+1)'(NCH * 8));

  // R5: per-frame mode steps by at most one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (no_rd0 && per_frame) |=> ((CNT_W+1)'(cnt) - (CNT_W+1)'($past(cnt))) <= (CNT_W+1)'(1));

  // R4: no count without a complete previous frame
  a_r4_no_first: assert property (@(posedge clk) disable iff (!rst_n)
    (no_rd0 && !have_prev) |=> $stable(cnt));

  // R9: a counter increase comes with the status bit
  a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_en) && cnt != $past(cnt)) |-> st);

  // R9: a status read with no new error clears the bit
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && rd_addr == 3'd4) && cnt == $past(cnt) && cnt != '1) |-> !st);

  // R10: a newly set status bit pulls the pin low when enabled
  a_r10_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st) && int_en) |-> !int_n);
endmodule

bind b2_monitor b2m_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_live), .have_prev(have_prev),
  .per_frame(per_frame), .rd_en(rd_en), .rd_addr(rd_addr),
  .st(st_q), .int_en(int_en), .int_n(int_n)
);

// File: tb/sim_b2_monitor.sv
module sim_b2_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 9 * 270;
  localparam int NVEC = 7;
  // {per_frame, mask byte0, mask byte1, mask byte2}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'h01, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b0, 8'hFF, 8'hFF, 8'hFF},
    {1'b0, 8'h81, 8'h00, 8'h0F},
    {1'b0, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h10, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, per_frame = 1, int_en = 1;
  logic [7:0] in_data = 0;
  logic rd_en = 0, u1_rd_en = 0;
  logic [2:0] rd_addr = 0;
  logic in_ready, int_n, u1_ready, u1_int_n;
  logic [7:0] rd_data, u1_rd_data;

  int nchk = 0, nerr = 0;
  logic [7:0] bprev [3];
  logic [7:0] rb;
  logic [31:0] val;
  int u1tot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  b2_monitor u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .per_frame(per_frame), .int_en(int_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .int_n(int_n));

  b2_monitor #(.CNT_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(u1_ready),
    .in_data(in_data), .in_sof(in_sof), .per_frame(per_frame), .int_en(int_en),
    .rd_en(u1_rd_en), .rd_addr(rd_addr), .rd_data(u1_rd_data), .int_n(u1_int_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fill(input int seed, input int r, input int c);
    return 8'(seed * 53 + r * 29 + c * 7 + (r ^ c));
  endfunction

  task automatic send_frame(input int seed, input logic [23:0] mask, input bit gap, input int nbytes);
    logic [7:0] acc [3];
    logic [7:0] d;
    int n;
    acc = '{8'h00, 8'h00, 8'h00};
    n = 0;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 270; c++) begin
        if (n < nbytes) begin
          d = (r == 4 && c < 3) ? (bprev[c] ^ mask[8*(2-c) +: 8]) : fill(seed, r, c);
          if (!(r < 3 && c < 9)) acc[c % 3] = acc[c % 3] ^ d;
          in_valid = 1; in_data = d; in_sof = (r == 0 && c == 0);
          @(negedge clk);
          if (gap && (n % 7 == 3)) begin
            in_valid = 0; in_data = 8'hA5; in_sof = 1;
            @(negedge clk);
          end
          n++;
        end
      end
    in_valid = 0; in_sof = 0;
    bprev = acc;
  endtask

  task automatic rd(input logic [2:0] a, input bit unit1, output logic [7:0] v);
    rd_addr = a;
    if (unit1) u1_rd_en = 1; else rd_en = 1;
    @(negedge clk);
    rd_en = 0; u1_rd_en = 0;
    v = unit1 ? u1_rd_data : rd_data;
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(3'(k), 0, b);
      v[8*k +: 8] = b;
    end
  endtask

  function automatic int pop24(input logic [23:0] m);
    int s = 0;
    for (int i = 0; i < 24; i++) s += int'(m[i]);
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    bprev = '{8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset int_n", 32'(int_n), 1);
    check("R1 in_ready", 32'(in_ready), 1);
    rd(3'd4, 0, rb); check("R9 reset status", 32'(rb), 0);
    rd_cnt(val); check("R8 reset counter", val, 0);

    // R4: errors in the first frame are not counted
    send_frame(1, 24'hFFFFFF, 0, FRAME);
    check("R4 first frame int_n", 32'(int_n), 1);
    rd(3'd4, 0, rb); check("R4 first frame status", 32'(rb), 0);
    rd_cnt(val); check("R4 first frame counter", val, 0);

    for (int i = 0; i < NVEC; i++) begin
      int exp;
      bit errf;
      per_frame = VEC[i][24];
      errf = (VEC[i][23:0] != 0);
      exp = per_frame ? int'(errf) : pop24(VEC[i][23:0]);
      send_frame(10 + i, VEC[i][23:0], i[0], FRAME);
      check(per_frame ? "R10 R5 int_n" : "R10 R6 int_n", 32'(int_n), errf ? 0 : 1);
      rd(3'd4, 0, rb); check("R9 R3 status", 32'(rb), errf ? 32'h10 : 0);
      check("R9 int_n after status read", 32'(int_n), 1);
      rd_cnt(val);
      check(per_frame ? "R5 R2 R3 per-frame delta" : "R6 R2 R3 per-bit delta", val, 32'(exp));
      u1tot += exp;
    end

    // R10: masked interrupt
    int_en = 0; per_frame = 1;
    send_frame(30, 24'h000001, 0, FRAME);
    check("R10 masked int_n", 32'(int_n), 1);
    rd(3'd4, 0, rb); check("R9 masked status", 32'(rb), 32'h10);
    rd(3'd4, 0, rb); check("R9 status cleared", 32'(rb), 0);
    rd_cnt(val); check("R5 masked delta", val, 1);
    u1tot += 1;
    int_en = 1;

    // R1: truncated frame then marker restarts the position
    per_frame = 0;
    send_frame(50, 24'h000000, 1, 100);
    send_frame(51, 24'h000000, 0, FRAME);
    rd_cnt(val); check("R1 resync clean", val, 0);
    send_frame(52, 24'h000300, 1, FRAME);
    rd_cnt(val); check("R3 channel 1 bits", val, 2);
    u1tot += 2;
    rd(3'd4, 0, rb);

    // R7 and R8: long run
    for (int f = 0; f < 11; f++) send_frame(60 + f, 24'hFFFFFF, 0, FRAME);
    rd(3'd0, 0, rb); check("R8 byte0", 32'(rb), 32'h08);
    rd(3'd1, 0, rb); check("R8 byte1", 32'(rb), 32'h01);
    rd(3'd2, 0, rb); check("R8 byte2", 32'(rb), 0);
    rd(3'd3, 0, rb); check("R8 byte3", 32'(rb), 0);
    rd(3'd1, 0, rb); check("R8 snapshot byte cleared", 32'(rb), 0);
    rd_cnt(val); check("R8 counter cleared", val, 0);
    u1tot += 264;
    rd(3'd0, 1, rb); check("R7 saturate", 32'(rb), (u1tot > 255) ? 32'hFF : 32'(u1tot));
    rd(3'd0, 1, rb); check("R7 cleared after read", 32'(rb), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule